// File: doc/BRIEF.md
# Interrupt Priority Arbitration Core

This block keeps the per-vector state of one local interrupt controller: a pending-request bit, an in-service bit and a trigger-mode bit for each of the 256 vectors. Each vector is an 8-bit number whose upper nibble is its priority class, and a higher number means a higher priority. Requests arrive one per cycle with an edge or level flag. The core derives the processor priority from a task-priority value and from the highest vector currently in service. It drives a registered interrupt line whenever the best pending request belongs to a class above that priority.

The processor claims an interrupt with a one-cycle acknowledge strobe. The core replies on the next cycle with either the winning vector, which moves from pending to in-service, or a programmable spurious vector. A one-cycle end-of-interrupt strobe retires the highest in-service vector. When the retired vector was level-triggered and directed end-of-interrupt mode is off, the core also emits a one-cycle broadcast that carries the vector number. Software reaches the task priority and the spurious/enable settings through two simple write strobes.

Top module: `irq_prio_core`

## Requirements
- R1: After reset nothing is pending or in service, irq_out, ack_valid and eoi_bcast are 0, and ppr_out is 0. The spurious setting resets to vector 0xFF with software enable off, so an acknowledge returns spurious vector 0xFF.
- R2: Among pending requests, an acknowledge picks the highest-numbered vector. Bits are ordered as eight 32-bit words, with vector n at word n/32, bit n%32.
- R3: A request with req_level=1 marks its vector level-triggered; with req_level=0 it marks the vector edge-triggered. The latest request for a vector decides its mode.
- R4: A write to the spurious setting keeps data bit 8 (software enable), data bit 12 (directed end-of-interrupt) and data bits [7:0] (spurious vector), and discards every other bit. With enable clear, irq_out stays low and acknowledge returns the spurious vector.
- R5: A pending request is blocked when ppr_out is nonzero and the request's bits [7:4] are less than or equal to ppr_out[7:4]. Otherwise it is deliverable.
- R6: An acknowledge with a deliverable request gives, one cycle after the strobe, ack_valid=1, ack_spurious=0 and ack_vector equal to the winner. The winner's pending bit is cleared and its in-service bit is set.
- R7: An acknowledge with no deliverable request gives ack_valid=1, ack_spurious=1 and ack_vector equal to the spurious vector. Pending and in-service state are left unchanged.
- R8: ppr_out equals the task priority when nothing is in service or when the task priority's bits [7:4] are at least those of the highest in-service vector. Otherwise ppr_out equals that vector with bits [3:0] cleared.
- R9: End-of-interrupt clears the highest in-service vector. One cycle after the strobe, eoi_bcast pulses for one cycle with eoi_bcast_vector set to that vector, but only if the vector is level-triggered and directed end-of-interrupt mode is off.
- R10: End-of-interrupt with nothing in service changes no state and gives no broadcast.
- R11: irq_out is a register loaded every cycle with the deliverability computed from the current state, so it follows a state change by one cycle.
- R12: When a request and an acknowledge fall in the same cycle, the acknowledge decides on the state before the request. A request for the vector being claimed leaves that vector pending again.
- R13: When an acknowledge and an end-of-interrupt fall in the same cycle, both act on the state before the edge. The claimed vector enters service and the previously highest in-service vector retires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Incoming vector request strobe |
| req_vector | input | 8 | Requested vector number |
| req_level | input | 1 | 1 = level-triggered, 0 = edge-triggered |
| tpr_wr | input | 1 | Task priority write strobe |
| tpr_data | input | 8 | Task priority value |
| svr_wr | input | 1 | Spurious/enable setting write strobe |
| svr_data | input | 32 | Written word; bits 12, 8 and [7:0] are kept |
| ack_req | input | 1 | Interrupt acknowledge strobe |
| eoi_req | input | 1 | End-of-interrupt strobe |
| irq_out | output | 1 | Registered interrupt request to the processor |
| ack_valid | output | 1 | Acknowledge reply valid, one cycle after ack_req |
| ack_vector | output | 8 | Vector returned by the acknowledge |
| ack_spurious | output | 1 | Reply carries the spurious vector |
| eoi_bcast | output | 1 | One-cycle end-of-interrupt broadcast pulse |
| eoi_bcast_vector | output | 8 | Vector retired by the broadcast |
| ppr_out | output | 8 | Current processor priority |

## Verification
Two pairs of functions can land on the same clock edge. A new request can coincide with an acknowledge that claims the same vector, and an acknowledge can coincide with an end-of-interrupt. The bench drives both strobes in one cycle and judges the outcome at the ports. For the first pair, the reply vector, the blocked irq_out that follows, and the broadcast mode of the next retirement must show that the late request re-armed the vector as level-triggered. For the second pair, the claimed vector and the broadcast of the retired one must both appear, and ppr_out must move to the new in-service class.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

  localparam int VEC_W = 8;
  localparam int NUM_VEC = 2 ** VEC_W;
  localparam int SVR_EN_BIT = 8;
  localparam int SVR_DIR_BIT = 12;

  typedef logic [VEC_W-1:0] vec_t;

  typedef struct packed {
    logic directed;
    logic enable;
    vec_t spur;
  } svr_t;

  // Keep only the enable, directed and spurious-vector fields of a write.
  function automatic svr_t svr_from_word(input logic [31:0] w);
    svr_t r;
    r.directed = w[SVR_DIR_BIT];
    r.enable   = w[SVR_EN_BIT];
    r.spur     = w[VEC_W-1:0];
    return r;
  endfunction

  // Processor priority from task priority and highest in-service vector.
  function automatic vec_t proc_prio(input vec_t tpr, input logic isr_any,
                                     input vec_t isr_top);
    if (!isr_any || (tpr[7:4] >= isr_top[7:4])) return tpr;
    return {isr_top[7:4], 4'h0};
  endfunction

  // Whether the best pending request beats the processor priority.
  function automatic logic may_deliver(input logic en, input logic irr_any,
                                       input vec_t irr_top, input vec_t ppr);
    if (!en || !irr_any) return 1'b0;
    if ((ppr != '0) && (irr_top[7:4] <= ppr[7:4])) return 1'b0;
    return 1'b1;
  endfunction

endpackage

// File: rtl/prio_vec_bank.sv
module prio_vec_bank #(
  parameter int NUM_BITS = 256,
  parameter int WORD_W   = 32,
  parameter int IDX_W    = $clog2(NUM_BITS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                set_en,
  input  logic [IDX_W-1:0]    set_idx,
  input  logic                clr_en,
  input  logic [IDX_W-1:0]    clr_idx,
  output logic [NUM_BITS-1:0] bits
);
  localparam int NUM_WORDS = NUM_BITS / WORD_W;
  localparam int SUB_W     = $clog2(WORD_W);
  localparam int SEL_W     = IDX_W - SUB_W;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    logic [WORD_W-1:0] word_q;
    logic [WORD_W-1:0] word_d;
    logic              clr_here;
    logic              set_here;

    assign clr_here = clr_en && (clr_idx[IDX_W-1:SUB_W] == SEL_W'(w));
    assign set_here = set_en && (set_idx[IDX_W-1:SUB_W] == SEL_W'(w));

    // Clear first, then set: a set of the same bit in the same cycle wins.
    always_comb begin
      word_d = word_q;
      if (clr_here) word_d[clr_idx[SUB_W-1:0]] = 1'b0;
      if (set_here) word_d[set_idx[SUB_W-1:0]] = 1'b1;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) word_q <= '0;
      else        word_q <= word_d;
    end

    assign bits[w*WORD_W +: WORD_W] = word_q;
  end

endmodule

// File: rtl/prio_msb_scan.sv
module prio_msb_scan #(
  parameter int NUM_BITS = 256,
  parameter int WORD_W   = 32,
  parameter int IDX_W    = $clog2(NUM_BITS)
) (
  input  logic [NUM_BITS-1:0] bits,
  output logic                found,
  output logic [IDX_W-1:0]    idx
);
  localparam int NUM_WORDS = NUM_BITS / WORD_W;
  localparam int SUB_W     = $clog2(WORD_W);

  function automatic logic [SUB_W-1:0] top_bit(input logic [WORD_W-1:0] w);
    logic [SUB_W-1:0] p;
    p = '0;
    for (int b = 0; b < WORD_W; b++) begin
      if (w[b]) p = SUB_W'(b);
    end
    return p;
  endfunction

  logic [NUM_WORDS-1:0] word_any;
  logic [SUB_W-1:0]     word_pos [NUM_WORDS];

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    assign word_any[w] = |bits[w*WORD_W +: WORD_W];
    assign word_pos[w] = top_bit(bits[w*WORD_W +: WORD_W]);
  end

  // Higher words override lower ones.
  always_comb begin
    idx = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (word_any[w]) idx = IDX_W'(w * WORD_W) + IDX_W'(word_pos[w]);
    end
  end

  assign found = |word_any;

endmodule

// File: rtl/prio_gate.sv
module prio_gate
  import irq_prio_pkg::*;
(
  input  vec_t tpr,
  input  logic sw_en,
  input  logic irr_any,
  input  vec_t irr_top,
  input  logic isr_any,
  input  vec_t isr_top,
  output vec_t ppr,
  output logic deliver
);
  assign ppr     = proc_prio(tpr, isr_any, isr_top);
  assign deliver = may_deliver(sw_en, irr_any, irr_top, ppr);
endmodule

// File: rtl/irq_prio_core.sv
module irq_prio_core
  import irq_prio_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [7:0]  req_vector,
  input  logic        req_level,
  input  logic        tpr_wr,
  input  logic [7:0]  tpr_data,
  input  logic        svr_wr,
  input  logic [31:0] svr_data,
  input  logic        ack_req,
  input  logic        eoi_req,
  output logic        irq_out,
  output logic        ack_valid,
  output logic [7:0]  ack_vector,
  output logic        ack_spurious,
  output logic        eoi_bcast,
  output logic [7:0]  eoi_bcast_vector,
  output logic [7:0]  ppr_out
);
  localparam int IDX_W = VEC_W;

  vec_t tpr_q;
  svr_t svr_q;

  logic [NUM_VEC-1:0] irr_bits, isr_bits, tmr_bits;
  logic irr_any, isr_any;
  vec_t irr_top, isr_top;
  vec_t ppr;
  logic deliver;

  // Named internal events
  logic ack_take;
  logic eoi_hit;
  logic bcast_fire;
  vec_t ack_reply;

  assign ack_take   = ack_req && deliver;
  assign eoi_hit    = eoi_req && isr_any;
  assign bcast_fire = eoi_hit && tmr_bits[isr_top] && !svr_q.directed;
  assign ack_reply  = ack_take ? irr_top : svr_q.spur;

  prio_vec_bank #(.NUM_BITS(NUM_VEC), .WORD_W(WORD_W), .IDX_W(IDX_W)) u_irr (
    .clk(clk), .rst_n(rst_n),
    .set_en(req_valid), .set_idx(req_vector),
    .clr_en(ack_take),  .clr_idx(irr_top),
    .bits(irr_bits)
  );

  prio_vec_bank #(.NUM_BITS(NUM_VEC), .WORD_W(WORD_W), .IDX_W(IDX_W)) u_isr (
    .clk(clk), .rst_n(rst_n),
    .set_en(ack_take), .set_idx(irr_top),
    .clr_en(eoi_hit),  .clr_idx(isr_top),
    .bits(isr_bits)
  );

  prio_vec_bank #(.NUM_BITS(NUM_VEC), .WORD_W(WORD_W), .IDX_W(IDX_W)) u_tmr (
    .clk(clk), .rst_n(rst_n),
    .set_en(req_valid && req_level),  .set_idx(req_vector),
    .clr_en(req_valid && !req_level), .clr_idx(req_vector),
    .bits(tmr_bits)
  );

  prio_msb_scan #(.NUM_BITS(NUM_VEC), .WORD_W(WORD_W), .IDX_W(IDX_W)) u_irr_scan (
    .bits(irr_bits), .found(irr_any), .idx(irr_top)
  );

  prio_msb_scan #(.NUM_BITS(NUM_VEC), .WORD_W(WORD_W), .IDX_W(IDX_W)) u_isr_scan (
    .bits(isr_bits), .found(isr_any), .idx(isr_top)
  );

  prio_gate u_gate (
    .tpr(tpr_q), .sw_en(svr_q.enable),
    .irr_any(irr_any), .irr_top(irr_top),
    .isr_any(isr_any), .isr_top(isr_top),
    .ppr(ppr), .deliver(deliver)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tpr_q            <= '0;
      svr_q            <= '{directed: 1'b0, enable: 1'b0, spur: 8'hFF};
      irq_out          <= 1'b0;
      ack_valid        <= 1'b0;
      ack_vector       <= '0;
      ack_spurious     <= 1'b0;
      eoi_bcast        <= 1'b0;
      eoi_bcast_vector <= '0;
    end else begin
      if (tpr_wr) tpr_q <= tpr_data;
      if (svr_wr) svr_q <= svr_from_word(svr_data);
      irq_out   <= deliver;
      ack_valid <= ack_req;
      if (ack_req) begin
        ack_vector   <= ack_reply;
        ack_spurious <= !ack_take;
      end
      eoi_bcast <= bcast_fire;
      if (bcast_fire) eoi_bcast_vector <= isr_top;
    end
  end

  assign ppr_out = ppr;

endmodule

// File: rtl/irq_prio_core_chk.sv
module irq_prio_core_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ack_req,
  input logic       eoi_req,
  input logic       ack_valid,
  input logic       ack_spurious,
  input logic       irq_out,
  input logic       eoi_bcast,
  input logic       sw_en,
  input logic       deliver,
  input logic       isr_any,
  input logic [7:0] isr_top,
  input logic [7:0] ppr_out
);

  assert_ack_reply_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req |=> ack_valid);

  assert_ack_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_req |=> !ack_valid);

  assert_spur_reply_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req && !deliver) |=> ack_spurious);

  assert_disabled_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_en |=> !irq_out);

  assert_ppr_floor_R8: assert property (@(posedge clk) disable iff (!rst_n)
    isr_any |-> (ppr_out[7:4] >= isr_top[7:4]));

  assert_bcast_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_bcast |-> $past(eoi_req));

  assert_eoi_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_req && !isr_any) |=> !eoi_bcast);

  assert_irq_rise_R11: assert property (@(posedge clk) disable iff (!rst_n)
    deliver |=> irq_out);

  assert_irq_fall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !deliver |=> !irq_out);

endmodule

bind irq_prio_core irq_prio_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ack_req(ack_req), .eoi_req(eoi_req),
  .ack_valid(ack_valid), .ack_spurious(ack_spurious), .irq_out(irq_out),
  .eoi_bcast(eoi_bcast), .sw_en(svr_q.enable), .deliver(deliver),
  .isr_any(isr_any), .isr_top(isr_top), .ppr_out(ppr_out)
);

// File: tb/sim_irq_prio_core.sv
`timescale 1ns/1ps
module sim_irq_prio_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [7:0]  req_vector = '0;
  logic        req_level = 1'b0;
  logic        tpr_wr = 1'b0;
  logic [7:0]  tpr_data = '0;
  logic        svr_wr = 1'b0;
  logic [31:0] svr_data = '0;
  logic        ack_req = 1'b0;
  logic        eoi_req = 1'b0;
  logic        irq_out, ack_valid, ack_spurious, eoi_bcast;
  logic [7:0]  ack_vector, eoi_bcast_vector, ppr_out;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_prio_core u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vector(req_vector),
    .req_level(req_level), .tpr_wr(tpr_wr), .tpr_data(tpr_data),
    .svr_wr(svr_wr), .svr_data(svr_data), .ack_req(ack_req), .eoi_req(eoi_req),
    .irq_out(irq_out), .ack_valid(ack_valid), .ack_vector(ack_vector),
    .ack_spurious(ack_spurious), .eoi_bcast(eoi_bcast),
    .eoi_bcast_vector(eoi_bcast_vector), .ppr_out(ppr_out)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic do_req(input int v, input bit lvl);
    req_valid = 1'b1; req_vector = 8'(v); req_level = lvl;
    tick();
    req_valid = 1'b0;
  endtask

  task automatic do_ack();
    ack_req = 1'b1; tick(); ack_req = 1'b0;
  endtask

  task automatic do_eoi();
    eoi_req = 1'b1; tick(); eoi_req = 1'b0;
  endtask

  task automatic wr_tpr(input int t);
    tpr_wr = 1'b1; tpr_data = 8'(t); tick(); tpr_wr = 1'b0;
  endtask

  task automatic wr_svr(input logic [31:0] d);
    svr_wr = 1'b1; svr_data = d; tick(); svr_wr = 1'b0;
  endtask

  task automatic expect_ack(input string tag, input int v, input bit spur);
    chk({tag, " ack_valid"}, ack_valid, 1);
    chk({tag, " ack_vector"}, ack_vector, v);
    chk({tag, " ack_spurious"}, ack_spurious, spur);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R1: reset state
    chk("R1 irq_out", irq_out, 0);
    chk("R1 ppr_out", ppr_out, 0);
    chk("R1 ack_valid", ack_valid, 0);
    chk("R1 eoi_bcast", eoi_bcast, 0);
    do_ack();
    expect_ack("R1 reset spurious", 8'hFF, 1);

    wr_svr(32'h0000_01E7);  // enable, spurious 0xE7

    // R2 R3 R6 R9 R11: every vector, alternating trigger mode
    for (int v = 0; v < 256; v++) begin
      bit lvl = v[0];
      do_req(v, lvl);
      tick();
      chk("R11 irq after request", irq_out, 1);
      do_ack();
      expect_ack("R6 sweep", v, 0);
      tick();
      chk("R8 ppr in service", ppr_out, v & 8'hF0);
      chk("R5 irq blocked by own class", irq_out, 0);
      do_eoi();
      chk("R3 broadcast by mode", eoi_bcast, lvl);
      if (lvl) chk("R9 broadcast vector", eoi_bcast_vector, v);
      tick();
      chk("R9 ppr after retire", ppr_out, 0);
      chk("R9 broadcast one cycle", eoi_bcast, 0);
    end

    // R5 R8: task priority against every request class
    for (int t = 0; t < 16; t++) begin
      for (int lo = 0; lo < 2; lo++) begin
        for (int c = 0; c < 16; c++) begin
          int tp = t * 16 + lo;
          int vec = c * 16 + 9;
          bit exp_ok = (tp == 0) || (c > t);
          wr_tpr(tp);
          chk("R8 ppr equals tpr", ppr_out, tp);
          do_req(vec, 1'b0);
          tick();
          chk("R5 irq vs priority", irq_out, exp_ok);
          do_ack();
          if (exp_ok) begin
            expect_ack("R5 delivered", vec, 0);
          end else begin
            expect_ack("R7 blocked", 8'hE7, 1);
            wr_tpr(0);
            do_ack();
            expect_ack("R7 state kept", vec, 0);
          end
          do_eoi();
          chk("R3 edge no broadcast", eoi_bcast, 0);
        end
      end
    end
    wr_tpr(0);

    // R8: in-service class versus task priority
    do_req(8'h30, 1'b0); do_ack();
    wr_tpr(8'h57);
    chk("R8 tpr above isr", ppr_out, 8'h57);
    wr_tpr(8'h25);
    chk("R8 isr above tpr", ppr_out, 8'h30);
    do_eoi(); wr_tpr(0);
    chk("R8 idle", ppr_out, 0);

    // R2: several pending, across words
    do_req(8'h31, 1'b1); do_req(8'h87, 1'b1); do_req(8'h5F, 1'b0); do_req(8'h86, 1'b1);
    do_ack(); expect_ack("R2 first", 8'h87, 0); do_eoi();
    chk("R9 bcast 87", eoi_bcast_vector, 8'h87);
    do_ack(); expect_ack("R2 second", 8'h86, 0); do_eoi();
    do_ack(); expect_ack("R2 third", 8'h5F, 0); do_eoi();
    chk("R3 5F edge", eoi_bcast, 0);
    do_ack(); expect_ack("R2 fourth", 8'h31, 0); do_eoi();

    // R9: nesting, retire highest in-service first
    do_req(8'h31, 1'b1); do_ack();
    do_req(8'h87, 1'b1); tick();
    chk("R5 nested preempt", irq_out, 1);
    do_ack(); expect_ack("R9 nested", 8'h87, 0);
    chk("R8 nested ppr", ppr_out, 8'h80);
    do_eoi();
    chk("R9 retire highest", eoi_bcast_vector, 8'h87);
    chk("R8 after first retire", ppr_out, 8'h30);
    do_eoi();
    chk("R9 retire next", eoi_bcast_vector, 8'h31);
    chk("R8 after all retired", ppr_out, 0);

    // R10: end-of-interrupt with nothing in service
    do_eoi();
    chk("R10 no broadcast", eoi_bcast, 0);
    chk("R10 ppr unchanged", ppr_out, 0);
    do_ack();
    expect_ack("R10 nothing pending", 8'hE7, 1);

    // R4: disabled, plus masking of written word
    wr_svr(32'hFFFF_F0C5);  // enable 0, directed 1, spurious C5
    do_req(8'h70, 1'b1); tick();
    chk("R4 disabled irq", irq_out, 0);
    do_ack(); expect_ack("R4 disabled ack", 8'hC5, 1);
    wr_svr(32'h0000_01E7); tick();
    chk("R4 re-enabled irq", irq_out, 1);
    do_ack(); expect_ack("R4 re-enabled ack", 8'h70, 0);
    do_eoi();
    chk("R9 level broadcast", eoi_bcast, 1);
    wr_svr(32'hFFFF_E13A);  // enable 1, directed 0, spurious 3A
    wr_tpr(8'hF0);
    do_req(8'h22, 1'b1); do_ack();
    expect_ack("R4 masked spurious", 8'h3A, 1);
    wr_tpr(0); do_ack();
    expect_ack("R4 masked enable", 8'h22, 0);
    do_eoi();
    chk("R4 masked directed off", eoi_bcast, 1);

    // R9: directed mode suppresses broadcast
    wr_svr(32'h0000_11E7);
    do_req(8'h44, 1'b1); do_ack(); do_eoi();
    chk("R9 directed no broadcast", eoi_bcast, 0);
    chk("R9 directed retired", ppr_out, 0);
    wr_svr(32'h0000_01E7);

    // R12: request and acknowledge in the same cycle
    do_req(8'h40, 1'b0);
    req_valid = 1'b1; req_vector = 8'h40; req_level = 1'b1; ack_req = 1'b1;
    tick();
    req_valid = 1'b0; ack_req = 1'b0;
    expect_ack("R12 claim", 8'h40, 0);
    tick();
    chk("R12 re-request blocked", irq_out, 0);
    do_eoi();
    chk("R12 now level", eoi_bcast, 1);
    chk("R12 vector", eoi_bcast_vector, 8'h40);
    tick();
    chk("R12 pending again", irq_out, 1);
    do_ack(); expect_ack("R12 second claim", 8'h40, 0);
    do_eoi();

    // R13: acknowledge and end-of-interrupt in the same cycle
    do_req(8'h20, 1'b1); do_ack();
    do_req(8'h90, 1'b0);
    ack_req = 1'b1; eoi_req = 1'b1;
    tick();
    ack_req = 1'b0; eoi_req = 1'b0;
    expect_ack("R13 claim", 8'h90, 0);
    chk("R13 retire broadcast", eoi_bcast, 1);
    chk("R13 retire vector", eoi_bcast_vector, 8'h20);
    chk("R13 ppr", ppr_out, 8'h90);
    do_eoi();
    chk("R13 edge retire", eoi_bcast, 0);
    chk("R13 idle", ppr_out, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule